// File: doc/BRIEF.md
# Byte-Stream Configuration Command Decoder

This block sits behind a UART receiver and turns its byte stream into configuration state for a display backlight controller. Every byte arrives as an 8-bit value qualified by a one-cycle valid strobe. The first byte of a frame is an opcode. The opcode alone fixes how many payload bytes follow: there is no length field and no terminator. The decoder writes those bytes in arrival order into one of three stores. The first is a 2-bit operating mode. The second is a table of per-region repeat counts, which tells the LED output stage how many LEDs each colour region feeds. The third is a table of per-region custom colour bytes.

The controller is a two-state machine. In ST_CMD it waits for an opcode. In ST_PAYLOAD it collects the payload into consecutive table indices, starting from index 0. Its transitions are named as follows. T_OPCODE goes from ST_CMD to ST_PAYLOAD when a known opcode arrives. T_DROP keeps ST_CMD on an unknown opcode. T_NEXT stays in ST_PAYLOAD and advances the index. T_DONE returns to ST_CMD on the last payload byte. T_TIMEOUT returns to ST_CMD after a long idle gap. T_CLEAR returns to ST_CMD on a synchronous clear. When a frame completes, a one-cycle update strobe reports which store changed, so downstream logic can reload.

Top module: `cmdcfg_decoder`

## Requirements
- R1: After reset the mode is 0, every entry of both tables is 0, and the update strobe is low.
- R2: Opcode 0x00 takes exactly one payload byte. The values 0 (off), 1 (averaged video) and 2 (custom colours) are stored as the mode.
- R3: A mode payload byte above 2 leaves the mode unchanged and raises no strobe. The byte still ends the frame, so the next byte is read as an opcode.
- R4: Opcode 0x01 takes exactly NUM_COUNTS payload bytes. Byte i goes to repeat-count entry i, which appears on count_tab_o bits [8i+7:8i].
- R5: Opcode 0x02 takes exactly NUM_REGIONS payload bytes. Byte i goes to colour entry i, which appears on color_tab_o bits [8i+7:8i].
- R6: In the cycle after the last payload byte of a completed frame is sampled, upd_valid_o is high for one cycle and upd_sel_o equals the opcode (0 mode, 1 counts, 2 colours). At no other time is it high.
- R7: An opcode byte above 0x02 is dropped and the next byte is read as an opcode.
- R8: Cycles with rx_valid_i low are ignored. An idle gap of up to TIMEOUT_CYCLES-1 cycles between payload bytes does not break a frame.
- R9: If TIMEOUT_CYCLES consecutive cycles pass in ST_PAYLOAD with no byte, the machine returns to ST_CMD. Bytes already stored remain, no strobe is raised, and the next byte is read as an opcode.
- R10: A synchronous clear returns the machine to ST_CMD and drops any byte presented in the same cycle. It leaves stored values unchanged.
- R11: A payload byte is always data, even when its value equals an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous return to opcode wait |
| rx_valid_i | input | 1 | Byte-valid strobe from the UART receiver |
| rx_data_i | input | 8 | Received byte |
| mode_o | output | 2 | Operating mode |
| count_tab_o | output | 8*NUM_COUNTS | Repeat-count table, entry i at [8i+7:8i] |
| color_tab_o | output | 8*NUM_REGIONS | Custom colour table, entry i at [8i+7:8i] |
| upd_valid_o | output | 1 | One-cycle update strobe |
| upd_sel_o | output | 2 | Store that changed when the strobe is high |

## Verification
The assertions assume that rx_data_i carries a defined value whenever rx_valid_i is high. They also assume that the clear input and the reset are the only ways the framing can be broken from outside. They rely on every frame being at least two bytes long, so two update strobes can never fall in adjacent cycles. The stimulus drives each byte as a single-cycle valid pulse, set up on the falling edge. Idle gaps are chosen on purpose either just below or exactly at the timeout window. The clear is raised together with a byte only in the case that checks whether that byte is dropped.

// File: rtl/cmdcfg_pkg.sv
`timescale 1ns/1ps
package cmdcfg_pkg;

    typedef enum logic [0:0] {
        ST_CMD     = 1'b0,
        ST_PAYLOAD = 1'b1
    } dec_state_e;

    typedef enum logic [1:0] {
        TGT_MODE  = 2'd0,
        TGT_COUNT = 2'd1,
        TGT_COLOR = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    localparam logic [7:0] OP_LAST   = 8'h02;
    localparam logic [7:0] MODE_LAST = 8'h02;

    function automatic logic opcode_known(input logic [7:0] b);
        return b <= OP_LAST;
    endfunction

    function automatic logic mode_legal(input logic [7:0] b);
        return b <= MODE_LAST;
    endfunction

endpackage

// File: rtl/cmdcfg_fsm.sv
`timescale 1ns/1ps
module cmdcfg_fsm
    import cmdcfg_pkg::*;
#(
    parameter int NUM_COUNTS  = 8,
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_data_i,
    input  logic             expire_i,
    output logic             active_o,
    output logic             wr_en_o,
    output tgt_e             wr_tgt_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             wr_last_o
);

    localparam logic [IDX_W-1:0] LAST_COUNT  = IDX_W'(NUM_COUNTS - 1);
    localparam logic [IDX_W-1:0] LAST_REGION = IDX_W'(NUM_REGIONS - 1);

    dec_state_e       state_q, state_n;
    tgt_e             tgt_q, tgt_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [IDX_W-1:0] last_idx;

    // Final index of the frame being collected
    always_comb begin
        unique case (tgt_q)
            TGT_COUNT: last_idx = LAST_COUNT;
            TGT_COLOR: last_idx = LAST_REGION;
            default:   last_idx = '0;
        endcase
    end

    // Transitions T_OPCODE, T_DROP, T_NEXT, T_DONE, T_TIMEOUT, T_CLEAR
    always_comb begin
        state_n = state_q;
        tgt_n   = tgt_q;
        idx_n   = idx_q;
        if (clear_i) begin
            state_n = ST_CMD;
            idx_n   = '0;
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (rx_valid_i && opcode_known(rx_data_i)) begin
                        state_n = ST_PAYLOAD;
                        tgt_n   = tgt_e'(rx_data_i[1:0]);
                        idx_n   = '0;
                    end
                end
                ST_PAYLOAD: begin
                    if (expire_i) begin
                        state_n = ST_CMD;
                        idx_n   = '0;
                    end else if (rx_valid_i) begin
                        if (idx_q == last_idx) begin
                            state_n = ST_CMD;
                            idx_n   = '0;
                        end else begin
                            idx_n = idx_q + 1'b1;
                        end
                    end
                end
                default: state_n = ST_CMD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            tgt_q   <= TGT_NONE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            tgt_q   <= tgt_n;
            idx_q   <= idx_n;
        end
    end

    // Outputs
    always_comb begin
        active_o  = (state_q == ST_PAYLOAD);
        wr_en_o   = (state_q == ST_PAYLOAD) && rx_valid_i && !clear_i;
        wr_tgt_o  = tgt_q;
        wr_idx_o  = idx_q;
        wr_data_o = rx_data_i;
        wr_last_o = wr_en_o && (idx_q == last_idx);
    end

    assert_clear_to_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> state_q == ST_CMD);

    assert_unknown_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && rx_valid_i && !clear_i && rx_data_i > OP_LAST)
        |=> state_q == ST_CMD);

    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PAYLOAD |-> idx_q <= last_idx);

    assert_expiry_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && expire_i) |=> state_q == ST_CMD);

endmodule

// File: rtl/cmdcfg_timeout.sv
`timescale 1ns/1ps
module cmdcfg_timeout #(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic rx_valid_i,
    output logic expire_o
);

    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = active_i && !rx_valid_i && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || rx_valid_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_expire_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (active_i && !rx_valid_i));

    assert_count_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> cnt_q == '0);

endmodule

// File: rtl/cmdcfg_regfile.sv
`timescale 1ns/1ps
module cmdcfg_regfile
    import cmdcfg_pkg::*;
#(
    parameter int NUM_COUNTS  = 8,
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  tgt_e                     wr_tgt_i,
    input  logic [IDX_W-1:0]         wr_idx_i,
    input  logic [7:0]               wr_data_i,
    input  logic                     wr_last_i,
    output logic [1:0]               mode_o,
    output logic [8*NUM_COUNTS-1:0]  count_tab_o,
    output logic [8*NUM_REGIONS-1:0] color_tab_o,
    output logic                     upd_valid_o,
    output logic [1:0]               upd_sel_o
);

    logic [1:0] mode_q;
    logic       upd_valid_q;
    logic [1:0] upd_sel_q;
    logic       mode_wr, mode_ok;

    assign mode_ok = mode_legal(wr_data_i);
    assign mode_wr = wr_en_i && (wr_tgt_i == TGT_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
        end else if (mode_wr && mode_ok) begin
            mode_q <= wr_data_i[1:0];
        end
    end

    for (genvar g = 0; g < NUM_COUNTS; g++) begin : g_count
        logic [7:0] entry_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (wr_en_i && wr_tgt_i == TGT_COUNT && wr_idx_i == IDX_W'(g)) begin
                entry_q <= wr_data_i;
            end
        end
        assign count_tab_o[8*g +: 8] = entry_q;
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_color
        logic [7:0] entry_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (wr_en_i && wr_tgt_i == TGT_COLOR && wr_idx_i == IDX_W'(g)) begin
                entry_q <= wr_data_i;
            end
        end
        assign color_tab_o[8*g +: 8] = entry_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid_q <= 1'b0;
            upd_sel_q   <= 2'd0;
        end else begin
            upd_valid_q <= wr_last_i && !(wr_tgt_i == TGT_MODE && !mode_ok);
            if (wr_last_i) begin
                upd_sel_q <= wr_tgt_i;
            end
        end
    end

    assign mode_o      = mode_q;
    assign upd_valid_o = upd_valid_q;
    assign upd_sel_o   = upd_sel_q;

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_q |=> !upd_valid_q);

    assert_strobe_sel_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_q |-> upd_sel_q != 2'd3);

    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'd3);

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_ok) |=> ($stable(mode_q) && !upd_valid_q));

endmodule

// File: rtl/cmdcfg_decoder.sv
`timescale 1ns/1ps
module cmdcfg_decoder
    import cmdcfg_pkg::*;
#(
    parameter int NUM_COUNTS     = 8,
    parameter int NUM_REGIONS    = 8,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     rx_valid_i,
    input  logic [7:0]               rx_data_i,
    output logic [1:0]               mode_o,
    output logic [8*NUM_COUNTS-1:0]  count_tab_o,
    output logic [8*NUM_REGIONS-1:0] color_tab_o,
    output logic                     upd_valid_o,
    output logic [1:0]               upd_sel_o
);

    localparam int MAX_LEN = (NUM_COUNTS > NUM_REGIONS) ? NUM_COUNTS : NUM_REGIONS;
    localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic             active, expire;
    logic             wr_en, wr_last;
    tgt_e             wr_tgt;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    cmdcfg_fsm #(
        .NUM_COUNTS (NUM_COUNTS),
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .rx_valid_i(rx_valid_i),
        .rx_data_i (rx_data_i),
        .expire_i  (expire),
        .active_o  (active),
        .wr_en_o   (wr_en),
        .wr_tgt_o  (wr_tgt),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .wr_last_o (wr_last)
    );

    cmdcfg_timeout #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) tmo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .rx_valid_i(rx_valid_i),
        .expire_o  (expire)
    );

    cmdcfg_regfile #(
        .NUM_COUNTS (NUM_COUNTS),
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_tgt_i   (wr_tgt),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .wr_last_i  (wr_last),
        .mode_o     (mode_o),
        .count_tab_o(count_tab_o),
        .color_tab_o(color_tab_o),
        .upd_valid_o(upd_valid_o),
        .upd_sel_o  (upd_sel_o)
    );

    assert_write_only_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (active && rx_valid_i));

endmodule

// File: tb/cmdcfg_decoder_tb_top.sv
`timescale 1ns/1ps
module cmdcfg_decoder_tb_top;

    localparam int NC = 6;
    localparam int NR = 5;
    localparam int TO = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clear_i = 1'b0;
    logic            rx_valid_i = 1'b0;
    logic [7:0]      rx_data_i = 8'h00;
    logic [1:0]      mode_o;
    logic [8*NC-1:0] count_tab_o;
    logic [8*NR-1:0] color_tab_o;
    logic            upd_valid_o;
    logic [1:0]      upd_sel_o;

    always #2.5 clk = ~clk;

    cmdcfg_decoder #(
        .NUM_COUNTS(NC), .NUM_REGIONS(NR), .TIMEOUT_CYCLES(TO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .mode_o(mode_o), .count_tab_o(count_tab_o), .color_tab_o(color_tab_o),
        .upd_valid_o(upd_valid_o), .upd_sel_o(upd_sel_o)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0]  sel;
        logic [63:0] val;
    } exp_item_t;
    exp_item_t sb_q[$];

    logic [1:0] exp_mode = 2'd0;
    logic [7:0] exp_cnt[NC];
    logic [7:0] exp_col[NR];

    function automatic logic [63:0] pack_cnt();
        logic [63:0] v = '0;
        for (int i = 0; i < NC; i++) v[8*i +: 8] = exp_cnt[i];
        return v;
    endfunction

    function automatic logic [63:0] pack_col();
        logic [63:0] v = '0;
        for (int i = 0; i < NR; i++) v[8*i +: 8] = exp_col[i];
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        rx_valid_i = 1'b1;
        rx_data_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_data_i  = 8'hEE;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_mode(input logic [7:0] v);
        exp_item_t it;
        if (v <= 8'd2) begin
            exp_mode = v[1:0];
            it.sel = 2'd0;
            it.val = 64'(v[1:0]);
            sb_q.push_back(it);
        end
        send_byte(8'h00, 1);
        send_byte(v, 2);
    endtask

    task automatic send_counts(input logic [7:0] v[NC], input int gap);
        exp_item_t it;
        for (int i = 0; i < NC; i++) exp_cnt[i] = v[i];
        it.sel = 2'd1;
        it.val = pack_cnt();
        sb_q.push_back(it);
        send_byte(8'h01, gap);
        for (int i = 0; i < NC; i++) send_byte(v[i], gap);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_colors(input logic [7:0] v[NR], input int gap);
        exp_item_t it;
        for (int i = 0; i < NR; i++) exp_col[i] = v[i];
        it.sel = 2'd2;
        it.val = pack_col();
        sb_q.push_back(it);
        send_byte(8'h02, gap);
        for (int i = 0; i < NR; i++) send_byte(v[i], gap);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare every update strobe with the scoreboard
    always @(negedge clk) begin
        if (rst_n && upd_valid_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", 64'(upd_sel_o), 64'hFF);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(upd_sel_o == it.sel, "R6 strobe select", 64'(upd_sel_o), 64'(it.sel));
                case (it.sel)
                    2'd0:    check(64'(mode_o) == it.val, "R2 mode value", 64'(mode_o), it.val);
                    2'd1:    check(64'(count_tab_o) == it.val, "R4 count table", 64'(count_tab_o), it.val);
                    default: check(64'(color_tab_o) == it.val, "R5 color table", 64'(color_tab_o), it.val);
                endcase
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] cv[NC];
        logic [7:0] kv[NR];
        for (int i = 0; i < NC; i++) exp_cnt[i] = 8'h00;
        for (int i = 0; i < NR; i++) exp_col[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(mode_o == 2'd0, "R1 mode", 64'(mode_o), 64'd0);
        check(count_tab_o == '0, "R1 counts", 64'(count_tab_o), 64'd0);
        check(color_tab_o == '0, "R1 colors", 64'(color_tab_o), 64'd0);
        check(upd_valid_o == 1'b0, "R1 strobe", 64'(upd_valid_o), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: legal mode values
        send_mode(8'd1);
        send_mode(8'd2);
        send_mode(8'd0);

        // R3: illegal mode value, then a normal frame right after
        send_mode(8'd7);
        check(mode_o == 2'd0, "R3 illegal mode ignored", 64'(mode_o), 64'd0);
        send_mode(8'd2);
        check(mode_o == 2'd2, "R3 next frame decoded", 64'(mode_o), 64'd2);

        // R4 + R11: counts back to back, payload contains opcode values
        cv = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFF, 8'h02};
        send_counts(cv, 0);
        // R5 + R8: colors with the longest allowed gap
        kv = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        send_colors(kv, TO - 1);
        check(64'(color_tab_o) == pack_col(), "R8 gap accepted", 64'(color_tab_o), pack_col());

        // R8: data without valid has no effect
        rx_data_i = 8'h02;
        repeat (5) @(negedge clk);
        check(mode_o == 2'd2, "R8 no valid no effect", 64'(mode_o), 64'd2);

        // R7: unknown opcode dropped, next byte is an opcode
        send_byte(8'h09, 1);
        send_mode(8'd1);
        check(mode_o == 2'd1, "R7 unknown opcode dropped", 64'(mode_o), 64'd1);

        // R9: timeout after two color bytes
        send_byte(8'h02, 0);
        send_byte(8'hA1, 0);
        send_byte(8'hA2, TO);
        exp_col[0] = 8'hA1;
        exp_col[1] = 8'hA2;
        check(64'(color_tab_o) == pack_col(), "R9 partial bytes kept", 64'(color_tab_o), pack_col());
        send_mode(8'd0);
        check(mode_o == 2'd0, "R9 back to opcode wait", 64'(mode_o), 64'd0);
        check(64'(color_tab_o) == pack_col(), "R9 colors untouched", 64'(color_tab_o), pack_col());

        // R10: clear mid-frame drops the byte presented with it
        send_byte(8'h01, 0);
        send_byte(8'h5A, 0);
        send_byte(8'h6B, 0);
        exp_cnt[0] = 8'h5A;
        exp_cnt[1] = 8'h6B;
        clear_i = 1'b1;
        rx_valid_i = 1'b1;
        rx_data_i = 8'h00;
        @(negedge clk);
        clear_i = 1'b0;
        rx_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        check(64'(count_tab_o) == pack_cnt(), "R10 counts kept", 64'(count_tab_o), pack_cnt());
        send_mode(8'd2);
        check(mode_o == 2'd2, "R10 decode after clear", 64'(mode_o), 64'd2);
        check(64'(count_tab_o) == pack_cnt(), "R10 clear byte dropped", 64'(count_tab_o), pack_cnt());

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R6 all strobes seen", 64'(sb_q.size()), 64'd0);
        finish_run();
    end

endmodule